// File: doc/BRIEF.md
# Keyboard Key-Code Latch

This block keeps the last key code delivered by a keyboard front end and offers it to an 8-bit processor bus as two read-only locations. A key arrives as a 7-bit code with a one-cycle valid pulse. It is stored with its top bit forced high, which tells software that a fresh key is waiting. One bus location returns the stored byte as it is. Reading the second location returns the byte with that top bit cleared, and the clear is written back into the store, so software acknowledges a key simply by reading there.

While a key is still unacknowledged, the block lowers its ready output so the key source holds the next code back. Only one entry is kept. The delete code (0x7F) is turned into the backspace code (0x08) before it is stored. Bus reads are answered one cycle later on a registered data path, with a hit flag for the two locations the block owns.

Top module: `keycode_latch`

## Requirements
- R1: A bus read (bus_rd=1, bus_wr=0) at the data location 0xC000 sets bus_hit=1 and bus_rdata to the stored byte, unchanged, on the clock edge that samples the read. The stored byte is not altered by the read.
- R2: A bus read at the acknowledge location 0xC010 sets bus_hit=1 and bus_rdata to the stored byte with bit 7 cleared, on the clock edge that samples the read. From that edge on, bit 7 of the stored byte is 0.
- R3: An accepted key code c (key_valid=1 while key_ready=1) is stored as {1'b1, c} at the next clock edge, so a later read at 0xC000 returns c + 0x80.
- R4: An accepted code of 0x7F is stored as 0x88, which is backspace 0x08 with bit 7 set. All other codes are stored unchanged in bits 6:0.
- R5: While bit 7 of the stored byte is 1, key_ready is 0, and a key_valid pulse leaves the stored byte unchanged.
- R6: A bus write (bus_wr=1) to 0xC000 or 0xC010 does not change the stored byte, does not clear bit 7, and gives bus_hit=0.
- R7: Synchronous active-high reset sets the stored byte to 0x00, bus_rdata to 0x00 and bus_hit to 0. After reset key_ready is 1.
- R8: In a cycle with a read at 0xC010, key_ready is 0 and no key is accepted. The acknowledge takes effect first, and a key still offered in the next cycle is accepted then.
- R9: A read at any other address, or a cycle with no read, gives bus_hit=0 and bus_rdata=0x00 one cycle later and leaves the stored byte unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| key_valid | input | 1 | Key source offers key_code this cycle |
| key_code | input | 7 | Key code from the source |
| key_ready | output | 1 | High when a key offered this cycle will be taken |
| bus_addr | input | 16 | Processor bus address |
| bus_rd | input | 1 | Read strobe for this cycle |
| bus_wr | input | 1 | Write strobe for this cycle; a write is never decoded as a read |
| bus_hit | output | 1 | Registered: the previous cycle read one of the block's two locations |
| bus_rdata | output | 8 | Registered read data, 0x00 when bus_hit is 0 |

## Verification
The embedded properties assume that every input is a known value at each rising edge and that reset is held high across at least one edge before any check is counted. They also assume the key source may keep key_valid high for several cycles or raise it while key_ready is low. The bench drives all inputs only on falling edges, holds reset for several cycles from time zero, and deliberately offers keys while one is pending and in the same cycle as an acknowledge read, so that both the held-off path and the acknowledge-first ordering are exercised without breaking those assumptions.

// File: rtl/keylatch_pkg.sv
package keylatch_pkg;

    localparam int KEY_W  = 7;
    localparam int BYTE_W = KEY_W + 1;

    typedef enum logic [1:0] {
        SEL_NONE   = 2'd0,
        SEL_DATA   = 2'd1,
        SEL_STROBE = 2'd2
    } bus_sel_e;

    typedef struct packed {
        logic              hit;
        logic [BYTE_W-1:0] data;
    } rd_resp_t;

    function automatic logic [BYTE_W-1:0] mark_unread(
        input logic [KEY_W-1:0] code,
        input logic [KEY_W-1:0] subst_from,
        input logic [KEY_W-1:0] subst_to
    );
        logic [KEY_W-1:0] mapped;
        mapped = (code == subst_from) ? subst_to : code;
        return {1'b1, mapped};
    endfunction

endpackage

// File: rtl/keylatch_decode.sv
module keylatch_decode
    import keylatch_pkg::*;
#(
    parameter int              ADDR_W      = 16,
    parameter logic [ADDR_W-1:0] DATA_ADDR   = 16'hC000,
    parameter logic [ADDR_W-1:0] STROBE_ADDR = 16'hC010
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic              wr,
    output bus_sel_e          sel
);

    logic is_read;
    assign is_read = rd && !wr;

    always_comb begin
        sel = SEL_NONE;
        if (is_read) begin
            if (addr == DATA_ADDR)
                sel = SEL_DATA;
            else if (addr == STROBE_ADDR)
                sel = SEL_STROBE;
        end
    end

endmodule

// File: rtl/keylatch_xlate.sv
module keylatch_xlate
    import keylatch_pkg::*;
#(
    parameter logic [KEY_W-1:0] SUBST_FROM = 7'h7F,
    parameter logic [KEY_W-1:0] SUBST_TO   = 7'h08
) (
    input  logic [KEY_W-1:0]  code_in,
    output logic [BYTE_W-1:0] code_out
);

    assign code_out = mark_unread(code_in, SUBST_FROM, SUBST_TO);

endmodule

// File: rtl/keylatch_store.sv
module keylatch_store
    import keylatch_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  bus_sel_e          sel,
    input  logic              key_valid,
    input  logic [BYTE_W-1:0] new_byte,
    output logic              key_ready,
    output logic [BYTE_W-1:0] held,
    output rd_resp_t          resp
);

    localparam int FLAG = BYTE_W - 1;

    logic strobe;
    logic accept;

    assign strobe    = (sel == SEL_STROBE);
    assign key_ready = !held[FLAG] && !strobe;
    assign accept    = key_valid && key_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            held <= '0;
        end else if (strobe) begin
            held <= {1'b0, held[FLAG-1:0]};
        end else if (accept) begin
            held <= new_byte;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            resp <= '0;
        end else begin
            unique case (sel)
                SEL_DATA:   resp <= '{hit: 1'b1, data: held};
                SEL_STROBE: resp <= '{hit: 1'b1, data: {1'b0, held[FLAG-1:0]}};
                default:    resp <= '0;
            endcase
        end
    end

    // R2: acknowledge read leaves the flag clear
    a_r2_strobe_clears: assert property (@(posedge clk) disable iff (rst)
        strobe |=> !held[FLAG]);

    // R5: a pending byte stays put until acknowledged
    a_r5_hold_pending: assert property (@(posedge clk) disable iff (rst)
        (held[FLAG] && !strobe) |=> $stable(held));

    // R3: a taken key shows up flagged as unread
    a_r3_flag_set: assert property (@(posedge clk) disable iff (rst)
        (key_valid && key_ready) |=> held[FLAG]);

endmodule

// File: rtl/keycode_latch.sv
module keycode_latch
    import keylatch_pkg::*;
#(
    parameter int                ADDR_W      = 16,
    parameter logic [ADDR_W-1:0] DATA_ADDR   = 16'hC000,
    parameter logic [ADDR_W-1:0] STROBE_ADDR = 16'hC010,
    parameter logic [6:0]        SUBST_FROM  = 7'h7F,
    parameter logic [6:0]        SUBST_TO    = 7'h08
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              key_valid,
    input  logic [6:0]        key_code,
    output logic              key_ready,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    output logic              bus_hit,
    output logic [7:0]        bus_rdata
);

    bus_sel_e          sel;
    logic [BYTE_W-1:0] new_byte;
    logic [BYTE_W-1:0] held;
    rd_resp_t          resp;

    keylatch_decode #(
        .ADDR_W      (ADDR_W),
        .DATA_ADDR   (DATA_ADDR),
        .STROBE_ADDR (STROBE_ADDR)
    ) u_decode (
        .addr (bus_addr),
        .rd   (bus_rd),
        .wr   (bus_wr),
        .sel  (sel)
    );

    keylatch_xlate #(
        .SUBST_FROM (SUBST_FROM),
        .SUBST_TO   (SUBST_TO)
    ) u_xlate (
        .code_in  (key_code),
        .code_out (new_byte)
    );

    keylatch_store u_store (
        .clk       (clk),
        .rst       (rst),
        .sel       (sel),
        .key_valid (key_valid),
        .new_byte  (new_byte),
        .key_ready (key_ready),
        .held      (held),
        .resp      (resp)
    );

    assign bus_hit   = resp.hit;
    assign bus_rdata = resp.data;

    // R1: data-location read returns the byte held at the read
    a_r1_data_read: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && !bus_wr && bus_addr == DATA_ADDR) |=> (bus_hit && bus_rdata == $past(held)));

    // R8: an acknowledge read holds the key source off in that cycle
    a_r8_strobe_blocks: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && !bus_wr && bus_addr == STROBE_ADDR) |-> !key_ready);

    // R9: nothing decoded gives a quiet response
    a_r9_quiet: assert property (@(posedge clk) disable iff (rst)
        (sel == SEL_NONE) |=> (!bus_hit && bus_rdata == 8'h00));

    // R6: a write never disturbs the stored byte
    a_r6_write_inert: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && !key_ready) |=> $stable(held));

endmodule

// File: tb/keycode_latch_bench.sv
module keycode_latch_bench;

    localparam logic [15:0] A_DATA = 16'hC000;
    localparam logic [15:0] A_ACK  = 16'hC010;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        key_valid = 1'b0;
    logic [6:0]  key_code = '0;
    logic        key_ready;
    logic [15:0] bus_addr = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_hit;
    logic [7:0]  bus_rdata;

    int checks   = 0;
    int failures = 0;
    logic [7:0] m_latch = 8'h00;

    always #5 clk = ~clk;

    keycode_latch u_keycode_latch (
        .clk       (clk),
        .rst       (rst),
        .key_valid (key_valid),
        .key_code  (key_code),
        .key_ready (key_ready),
        .bus_addr  (bus_addr),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_hit   (bus_hit),
        .bus_rdata (bus_rdata)
    );

    task automatic check(input logic ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%02h expected=%02h", tag, what, act, exp);
        end
    endtask

    // one bus/key cycle against the behavioural model
    task automatic cycle(input logic [15:0] a, input logic rd, input logic wr,
                         input logic kv, input logic [6:0] kc, input string tag);
        logic       is_ack, is_data, exp_rdy, exp_hit;
        logic [7:0] exp_data;
        @(negedge clk);
        bus_addr = a; bus_rd = rd; bus_wr = wr; key_valid = kv; key_code = kc;
        #1;
        is_ack  = rd && !wr && a == A_ACK;
        is_data = rd && !wr && a == A_DATA;
        exp_rdy = !m_latch[7] && !is_ack;
        check(key_ready == exp_rdy, tag, "key_ready", key_ready, exp_rdy);
        exp_hit  = is_ack || is_data;
        exp_data = is_data ? m_latch : (is_ack ? (m_latch & 8'h7F) : 8'h00);
        if (is_ack)
            m_latch = m_latch & 8'h7F;
        else if (kv && exp_rdy)
            m_latch = 8'h80 | ((kc == 7'h7F) ? 8'h08 : {1'b0, kc});
        @(posedge clk);
        #1;
        check(bus_hit == exp_hit, tag, "bus_hit", bus_hit, exp_hit);
        check(bus_rdata == exp_data, tag, "bus_rdata", bus_rdata, exp_data);
    endtask

    task automatic idle(input string tag);
        cycle(16'h0000, 1'b0, 1'b0, 1'b0, 7'h00, tag);
    endtask

    initial begin
        #2_000_000;
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=0", 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        #1;
        check(key_ready == 1'b1, "R7", "key_ready in reset", key_ready, 1);
        check(bus_hit == 1'b0, "R7", "bus_hit in reset", bus_hit, 0);
        check(bus_rdata == 8'h00, "R7", "bus_rdata in reset", bus_rdata, 0);
        @(negedge clk);
        rst = 1'b0;

        // R7 / R1: empty latch reads back zero
        cycle(A_DATA, 1, 0, 0, 7'h00, "R7");
        check(bus_rdata == 8'h00, "R7", "latch after reset", bus_rdata, 8'h00);

        // R3: key 'A' stored flagged
        cycle(16'h0000, 0, 0, 1, 7'h41, "R3");
        cycle(A_DATA, 1, 0, 0, 7'h00, "R1");
        check(bus_rdata == 8'hC1, "R3", "stored key", bus_rdata, 8'hC1);
        cycle(A_DATA, 1, 0, 0, 7'h00, "R1");

        // R5: second key held off
        cycle(16'h0000, 0, 0, 1, 7'h42, "R5");
        cycle(A_DATA, 1, 0, 0, 7'h00, "R5");
        check(bus_rdata == 8'hC1, "R5", "pending key kept", bus_rdata, 8'hC1);

        // R6: writes to both locations
        cycle(A_DATA, 0, 1, 0, 7'h00, "R6");
        cycle(A_ACK,  1, 1, 0, 7'h00, "R6");
        cycle(A_DATA, 1, 0, 0, 7'h00, "R6");
        check(bus_rdata == 8'hC1, "R6", "after writes", bus_rdata, 8'hC1);

        // R9: other addresses
        cycle(16'hC001, 1, 0, 0, 7'h00, "R9");
        cycle(16'h1234, 1, 0, 0, 7'h00, "R9");
        cycle(A_DATA, 1, 0, 0, 7'h00, "R9");

        // R2: acknowledge
        cycle(A_ACK, 1, 0, 0, 7'h00, "R2");
        check(bus_rdata == 8'h41, "R2", "ack read value", bus_rdata, 8'h41);
        cycle(A_DATA, 1, 0, 0, 7'h00, "R2");
        check(bus_rdata == 8'h41, "R2", "flag cleared", bus_rdata, 8'h41);

        // R4: delete becomes backspace
        cycle(16'h0000, 0, 0, 1, 7'h7F, "R4");
        cycle(A_DATA, 1, 0, 0, 7'h00, "R4");
        check(bus_rdata == 8'h88, "R4", "mapped code", bus_rdata, 8'h88);

        // R8: ack and key in the same cycle, key accepted next cycle
        cycle(A_ACK, 1, 0, 1, 7'h33, "R8");
        cycle(16'h0000, 0, 0, 1, 7'h33, "R8");
        cycle(A_DATA, 1, 0, 0, 7'h00, "R8");
        check(bus_rdata == 8'hB3, "R8", "key after ack", bus_rdata, 8'hB3);
        cycle(A_ACK, 1, 0, 0, 7'h00, "R8");
        // R8: flag already clear, ack still wins that cycle
        cycle(A_ACK, 1, 0, 1, 7'h12, "R8");
        cycle(A_DATA, 1, 0, 0, 7'h00, "R8");
        check(bus_rdata == 8'h33, "R8", "no take during ack", bus_rdata, 8'h33);
        idle("R9");

        // mixed traffic: R1 R2 R3 R4 R5 R6 R9
        for (int i = 0; i < 400; i++) begin
            logic [15:0] a;
            logic [2:0]  pick;
            logic [6:0]  kc;
            pick = 3'($urandom_range(0, 4));
            a = (pick == 0) ? A_DATA : (pick == 1) ? A_ACK :
                (pick == 2) ? 16'hC011 : 16'($urandom);
            kc = ($urandom_range(0, 5) == 0) ? 7'h7F : 7'($urandom);
            cycle(a, 1'($urandom), 1'($urandom_range(0, 5) == 0),
                  1'($urandom), kc, "R1/R2/R3/R4/R5/R6/R9");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule